// File: doc/BRIEF.md
# Shared-Inverse AES Byte Substitution

This unit computes the AES byte substitution or its inverse for a single byte. Both directions go through one 256-entry multiplicative-inverse table over GF(2^8), reduction polynomial x^8+x^4+x^3+x+1. In the encrypt direction the byte is looked up in the table and the result then goes through the affine transform. In the decrypt direction the byte first goes through the inverse affine transform and then through the same table. A direction bit drives two multiplexers. The first picks the table address: the raw byte or the inverse-affine output. The second picks the result: the affine output or the raw table output.

A parent datapath places one copy of this unit per state byte. It presents a byte with `in_vld` high and receives the substituted byte one clock later, registered. The table contents are computed at elaboration time and are not loaded. The two affine steps are separate logic outside the table.

Top module: `sbx_shared_sub`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first valid input, `out_vld` is 0 and `out_byte` is 0x00.
- R2: With `dir_dec`=0 (encrypt), the output is A(inv(x)), where inv is the GF(2^8) multiplicative inverse. A sets bit i to x[i]^x[(i+4)%8]^x[(i+5)%8]^x[(i+6)%8]^x[(i+7)%8], XORed with bit i of the constant 0x63.
- R3: With `dir_dec`=1 (decrypt), the output is inv(B(x)). B sets bit i to x[(i+2)%8]^x[(i+5)%8]^x[(i+7)%8], XORed with bit i of the constant 0x05.
- R4: The inverse of 0x00 is taken as 0x00, so encrypting 0x00 gives 0x63 and decrypting 0x63 gives 0x00.
- R5: `out_vld` equals the value `in_vld` had one clock earlier. A result accepted on one edge appears on `out_byte` after that same edge.
- R6: While `in_vld` is low, `out_byte` holds its last value, whatever `in_byte` and `dir_dec` do.
- R7: Decrypting the encrypted form of any byte returns that byte. Encrypting 0x53 gives 0xED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_byte | input | 8 | Byte to substitute |
| dir_dec | input | 1 | 0 = forward (encrypt), 1 = inverse (decrypt) |
| in_vld | input | 1 | Input byte is valid this cycle |
| out_byte | output | 8 | Registered substituted byte |
| out_vld | output | 1 | Output byte is valid |

## Verification
The assertions assume that `in_byte` and `dir_dec` are known, not X or Z, in every cycle where `in_vld` is high. The table-inverse check and the round-trip check evaluate field products of those values. The bench drives every input from a known value at a falling edge, so no X ever reaches the mux or the table while `in_vld` is high.

Stimulus covers all 256 bytes in each direction, plus a seeded random round-trip run. Idle stretches drive random bytes and direction changes while `in_vld` is low.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

    localparam int BYTE_W   = 8;
    localparam int TBL_SIZE = 1 << BYTE_W;
    localparam logic [BYTE_W-1:0] POLY_LOW  = 8'h1b;
    localparam logic [BYTE_W-1:0] FWD_CONST = 8'h63;
    localparam logic [BYTE_W-1:0] REV_CONST = 8'h05;

    // GF(2^8) product, shift-and-add with reduction
    function automatic logic [BYTE_W-1:0] gf_mul8(input logic [BYTE_W-1:0] a,
                                                  input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[BYTE_W-2:0], 1'b0} ^ (sh[BYTE_W-1] ? POLY_LOW : '0);
        end
        return acc;
    endfunction

    // Inverse as a^254; zero maps to zero
    function automatic logic [BYTE_W-1:0] gf_inv8(input logic [BYTE_W-1:0] a);
        logic [BYTE_W-1:0] r;
        logic [BYTE_W-1:0] s;
        r = 8'h01;
        s = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (i != 0) r = gf_mul8(r, s);
            s = gf_mul8(s, s);
        end
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] rotl8(input logic [BYTE_W-1:0] v, input int n);
        return (v << n) | (v >> (BYTE_W - n));
    endfunction

endpackage

// File: rtl/sbx_inv_rom.sv
module sbx_inv_rom
    import sbx_pkg::*;
(
    input  logic [BYTE_W-1:0] addr,
    output logic [BYTE_W-1:0] q
);

    logic [BYTE_W-1:0] tbl [TBL_SIZE];

    for (genvar g = 0; g < TBL_SIZE; g++) begin : g_ent
        assign tbl[g] = gf_inv8(BYTE_W'(g));
    end

    assign q = tbl[addr];

endmodule

// File: rtl/sbx_affine.sv
module sbx_affine
    import sbx_pkg::*;
#(
    parameter bit REVERSE = 1'b0
) (
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);

    if (REVERSE) begin : g_rev
        assign dout = rotl8(din, 1) ^ rotl8(din, 3) ^ rotl8(din, 6) ^ REV_CONST;
    end else begin : g_fwd
        assign dout = din ^ rotl8(din, 1) ^ rotl8(din, 2) ^ rotl8(din, 3)
                    ^ rotl8(din, 4) ^ FWD_CONST;
    end

endmodule

// File: rtl/sbx_shared_sub.sv
module sbx_shared_sub
    import sbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              dir_dec,
    input  logic              in_vld,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_vld
);

    logic [BYTE_W-1:0] rev_out;
    logic [BYTE_W-1:0] inv_addr;
    logic [BYTE_W-1:0] inv_q;
    logic [BYTE_W-1:0] fwd_out;
    logic [BYTE_W-1:0] result;

    sbx_affine #(.REVERSE(1'b1)) u_rev (.din(in_byte), .dout(rev_out));

    // address multiplexer
    assign inv_addr = dir_dec ? rev_out : in_byte;

    sbx_inv_rom u_rom (.addr(inv_addr), .q(inv_q));

    sbx_affine #(.REVERSE(1'b0)) u_fwd (.din(inv_q), .dout(fwd_out));

    // result multiplexer
    assign result = dir_dec ? inv_q : fwd_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_byte <= '0;
            out_vld  <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) out_byte <= result;
        end
    end

    // R2 R3 table output is a true field inverse of its address
    rom_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && inv_addr != '0) |-> (gf_mul8(inv_addr, inv_q) == 8'h01));

    // R4
    zero_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !dir_dec && in_byte == '0) |=> (out_byte == FWD_CONST));

    // R5
    vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    // R5
    vld_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_byte));

    // R7 decrypt output re-encrypts to the accepted byte
    round_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && dir_dec) |=>
            (rotl8(gf_inv8(out_byte), 0) ^ rotl8(gf_inv8(out_byte), 1)
             ^ rotl8(gf_inv8(out_byte), 2) ^ rotl8(gf_inv8(out_byte), 3)
             ^ rotl8(gf_inv8(out_byte), 4) ^ FWD_CONST) == $past(in_byte));

endmodule

// File: tb/sbx_shared_sub_test.sv
module sbx_shared_sub_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       dir_dec = 1'b0;
    logic       in_vld = 1'b0;
    logic [7:0] out_byte;
    logic       out_vld;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sbx_shared_sub uut (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .dir_dec(dir_dec),
        .in_vld(in_vld), .out_byte(out_byte), .out_vld(out_vld)
    );

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] ref_inv(input logic [7:0] a);
        if (a == 8'h00) return 8'h00;
        for (int y = 1; y < 256; y++)
            if (ref_mul(a, 8'(y)) == 8'h01) return 8'(y);
        return 8'h00;
    endfunction

    function automatic logic [7:0] ref_aff(input logic [7:0] x);
        logic [7:0] b;
        for (int i = 0; i < 8; i++)
            b[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8];
        return b ^ 8'h63;
    endfunction

    function automatic logic [7:0] ref_raff(input logic [7:0] x);
        logic [7:0] b;
        for (int i = 0; i < 8; i++)
            b[i] = x[(i+2)%8] ^ x[(i+5)%8] ^ x[(i+7)%8];
        return b ^ 8'h05;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // apply one valid byte, sample after the capturing edge
    task automatic apply(input logic [7:0] b, input logic dec, output logic [7:0] got);
        @(negedge clk);
        in_byte = b; dir_dec = dec; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        got = out_byte;
    endtask

    initial begin
        logic [7:0] got;
        logic [7:0] enc;
        logic [7:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 out_vld in reset", {7'd0, out_vld}, 8'h00);
        check("R1 out_byte in reset", out_byte, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_vld after reset", {7'd0, out_vld}, 8'h00);
        check("R1 out_byte after reset", out_byte, 8'h00);

        // directed corners
        apply(8'h00, 1'b0, got); check("R4 enc 00", got, 8'h63);
        apply(8'h63, 1'b1, got); check("R4 dec 63", got, 8'h00);
        apply(8'h53, 1'b0, got); check("R7 enc 53", got, 8'hED);
        apply(8'hED, 1'b1, got); check("R7 dec ED", got, 8'h53);

        // R5 valid timing, back-to-back
        @(negedge clk);
        in_byte = 8'h01; dir_dec = 1'b0; in_vld = 1'b1;
        check("R5 out_vld before edge", {7'd0, out_vld}, 8'h00);
        @(negedge clk);
        check("R5 out_vld after edge", {7'd0, out_vld}, 8'h01);
        check("R2 enc 01", out_byte, 8'h7C);
        in_byte = 8'hFF; dir_dec = 1'b1;
        @(negedge clk);
        check("R5 out_vld stays high", {7'd0, out_vld}, 8'h01);
        check("R3 dec FF", out_byte, 8'h7D);
        in_vld = 1'b0;
        @(negedge clk);
        check("R5 out_vld drops", {7'd0, out_vld}, 8'h00);

        // full sweeps
        for (int v = 0; v < 256; v++) begin
            apply(8'(v), 1'b0, got);
            check("R2 enc sweep", got, ref_aff(ref_inv(8'(v))));
        end
        for (int v = 0; v < 256; v++) begin
            apply(8'(v), 1'b1, got);
            check("R3 dec sweep", got, ref_inv(ref_raff(8'(v))));
        end

        // R6 hold while idle with random stimulus
        apply(8'hA5, 1'b0, held);
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            in_byte = 8'($urandom); dir_dec = 1'($urandom); in_vld = 1'b0;
            @(negedge clk);
            check("R6 hold idle", out_byte, held);
            check("R6 out_vld idle", {7'd0, out_vld}, 8'h00);
        end

        // R7 random round trips
        for (int n = 0; n < 200; n++) begin
            logic [7:0] x;
            x = 8'($urandom);
            apply(x, 1'b0, enc);
            apply(enc, 1'b1, got);
            check("R7 round trip", got, x);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule